// File: doc/BRIEF.md
# Cascadable Event Counter

The block holds two 8-bit up-counters, a low half and a high half, that either run side by side as two separate 8-bit counters fed by the same count source, or chain into one 16-bit counter in which the low half's wrap advances the high half. The count source is chosen by software. It is either rising edges on an asynchronous event pin, or the system clock divided by 2, 4 or 8. The event pin is resynchronised through two flops and edge-detected before it can advance a count.

Software reaches the block through a small register port with a 2-bit address and a combinational read. It reads both counts, selects the mode and the source, clears either half with a self-clearing strobe, and freezes both counters through an active-low standby bit. A one-cycle carry output marks each wrap of the high half.

Top module: `evtcnt_top`

## Requirements
- R1: After reset both counts read 0x00, the control register (address 2) reads 0x00 and the standby register (address 3) reads 0xFF.
- R2: Address 0 reads the low count and address 1 reads the high count. Address 2 holds the cascade bit in bit 0 and the source code in bits 2:1, and reads back only those bits. Address 3 stores and returns all 8 written bits.
- R3: Writes to address 0 or address 1 leave both counts unchanged.
- R4: Source codes 1, 2 and 3 advance the count once every 2, 4 and 8 system clock cycles.
- R5: Writing 1 to control bit 4 clears the low count and writing 1 to control bit 5 clears the high count. These bits are strobes and are not stored. A clear works during standby and wins over a count in the same cycle.
- R6: With source code 0, each rising edge on the event pin advances the count exactly once, on the third clock edge after the pin is first sampled high. A level held high counts only once.
- R7: When bit 3 of the standby register is 0, both counts hold their value and ignore all count events.
- R8: With the cascade bit set, the high count advances in the same cycle that the low count wraps from 0xFF to 0x00, and the 16-bit value wraps from 0xFFFF to 0x0000.
- R9: With the cascade bit clear, the high count advances on every count event of the selected source, independently of the low count.
- R10: `carryOut` is high for exactly one cycle after each cycle in which the high count wraps from 0xFF to 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 2 | Register address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data of the addressed register (combinational) |
| evtPin | input | 1 | Asynchronous event input |
| carryOut | output | 1 | One-cycle pulse after the high count wraps |

## Verification
The bench times a software clear to land on the same clock edge as an event-pin increment. A design that lets the count win would read 1 where 0 is expected. It measures each prescaled rate over a window that is an exact multiple of the divider, so a wrong divider tap shows up as a wrong total. The bench also checks that a held pin level counts once and at the expected latency. A missing edge detector would run the count away, and a missing or extra synchronizer stage would shift the increment by a cycle. It runs the 16-bit chain through 0xFF and through 0xFFFF. A carry lost between the halves, or a high half that counts in cascade mode as if split, leaves the wrong high byte and the wrong number of carry pulses.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;
  localparam int REG_W  = 8;
  localparam int ADDR_W = 2;
  localparam int PRE_W  = 3;
  localparam int SRC_W  = $clog2(PRE_W + 1);

  localparam logic [ADDR_W-1:0] ADR_LO   = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_HI   = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_CTL  = 2'd2;
  localparam logic [ADDR_W-1:0] ADR_STBY = 2'd3;

  localparam int CTL_CASC    = 0;
  localparam int CTL_SRC_LSB = 1;
  localparam int CTL_CLRLO   = 4;
  localparam int CTL_CLRHI   = 5;
  localparam int STBY_BIT    = 3;

  localparam logic [REG_W-1:0] CTL_MASK = REG_W'((1 << (CTL_SRC_LSB + SRC_W)) - 1);

  typedef enum logic [SRC_W-1:0] {
    SRC_PIN  = 2'd0,
    SRC_DIV2 = 2'd1,
    SRC_DIV4 = 2'd2,
    SRC_DIV8 = 2'd3
  } srcSel_e;

  typedef struct packed {
    logic tick;
    logic clrLo;
    logic clrHi;
    logic cascade;
    logic hold;
  } cntStrobe_t;
endpackage

// File: rtl/evtcnt_ctrl.sv
module evtcnt_ctrl
  import evtcnt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [REG_W-1:0]  busWrData,
  input  logic              evtPin,
  output logic [REG_W-1:0]  ctlQ,
  output logic [REG_W-1:0]  stbyQ,
  output cntStrobe_t        strb
);
  logic [PRE_W-1:0] pre;
  logic [1:0]       evtSync;
  logic             evtPrev;
  logic             evtRise;
  logic [PRE_W:0]   divTick;
  logic [SRC_W-1:0] srcSel;
  logic             ctlWr;

  assign ctlWr  = busWrEn && (busAddr == ADR_CTL);
  assign srcSel = ctlQ[CTL_SRC_LSB +: SRC_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ  <= '0;
      stbyQ <= '1;
    end else if (busWrEn) begin
      if (busAddr == ADR_CTL)  ctlQ  <= busWrData & CTL_MASK;
      if (busAddr == ADR_STBY) stbyQ <= busWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pre <= '0;
    else       pre <= pre + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtSync <= '0;
      evtPrev <= 1'b0;
    end else begin
      evtSync <= {evtSync[0], evtPin};
      evtPrev <= evtSync[1];
    end
  end

  assign evtRise    = evtSync[1] & ~evtPrev;
  assign divTick[0] = evtRise;

  for (genvar k = 1; k <= PRE_W; k++) begin : g_div
    assign divTick[k] = &pre[k-1:0];
  end

  always_comb begin
    strb.tick    = divTick[srcSel];
    strb.clrLo   = ctlWr && busWrData[CTL_CLRLO];
    strb.clrHi   = ctlWr && busWrData[CTL_CLRHI];
    strb.cascade = ctlQ[CTL_CASC];
    strb.hold    = ~stbyQ[STBY_BIT];
  end

  // R6
  rise_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    evtRise |=> !evtRise);

  // R4
  div_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    divTick[PRE_W] |=> !divTick[PRE_W]);
endmodule

// File: rtl/evtcnt_datapath.sv
module evtcnt_datapath
  import evtcnt_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  cntStrobe_t    strb,
  output logic [CW-1:0] loQ,
  output logic [CW-1:0] hiQ,
  output logic          carryQ
);
  logic incLo;
  logic incHi;
  logic loMax;
  logic hiMax;

  assign loMax = &loQ;
  assign hiMax = &hiQ;
  assign incLo = strb.tick & ~strb.hold;
  assign incHi = strb.cascade ? (incLo & loMax) : incLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          loQ <= '0;
    else if (strb.clrLo) loQ <= '0;
    else if (incLo)     loQ <= loQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          hiQ <= '0;
    else if (strb.clrHi) hiQ <= '0;
    else if (incHi)     hiQ <= hiQ + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) carryQ <= 1'b0;
    else       carryQ <= incHi & hiMax & ~strb.clrHi;
  end

  // R5
  clr_lo_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrLo |=> (loQ == '0));

  // R7
  hold_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hold && !strb.clrLo) |=> $stable(loQ));

  // R7
  hold_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.hold && !strb.clrHi) |=> $stable(hiQ));

  // R8
  casc_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cascade && !strb.hold && strb.tick && (loQ == {CW{1'b1}}) && !strb.clrHi)
      |=> (hiQ == CW'($past(hiQ) + 1'b1)));

  // R9
  split_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cascade && !strb.hold && strb.tick && !strb.clrHi)
      |=> (hiQ == CW'($past(hiQ) + 1'b1)));

  // R10
  carry_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    carryQ |-> (hiQ == '0));
endmodule

// File: rtl/evtcnt_top.sv
module evtcnt_top
  import evtcnt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  busAddr,
  input  logic        busWrEn,
  input  logic [7:0]  busWrData,
  output logic [7:0]  busRdData,
  input  logic        evtPin,
  output logic        carryOut
);
  cntStrobe_t       strb;
  logic [REG_W-1:0] ctlQ;
  logic [REG_W-1:0] stbyQ;
  logic [REG_W-1:0] loQ;
  logic [REG_W-1:0] hiQ;

  evtcnt_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .evtPin    (evtPin),
    .ctlQ      (ctlQ),
    .stbyQ     (stbyQ),
    .strb      (strb)
  );

  evtcnt_datapath #(.CW(REG_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .loQ    (loQ),
    .hiQ    (hiQ),
    .carryQ (carryOut)
  );

  always_comb begin
    unique case (busAddr)
      ADR_LO:   busRdData = loQ;
      ADR_HI:   busRdData = hiQ;
      ADR_CTL:  busRdData = ctlQ;
      default:  busRdData = stbyQ;
    endcase
  end

  // R3
  ro_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && (busAddr == ADR_LO) && strb.hold) |=> $stable(loQ));
endmodule

// File: tb/evtcnt_top_bench.sv
module evtcnt_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'd0;
  logic [7:0] busRdData;
  logic       evtPin = 1'b0;
  logic       carryOut;

  int total = 0;
  int bad = 0;
  int carryCnt = 0;

  typedef struct {
    string      tag;
    logic [7:0] exp;
  } item_t;
  item_t sbq[$];

  evtcnt_top u_evtcnt_top (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .evtPin(evtPin),
    .carryOut(carryOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rstN && carryOut) carryCnt++;

  // monitor: pops expected items and compares the read port
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sbq.size() > 0) begin
        item_t it;
        it = sbq.pop_front();
        total++;
        if (busRdData !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=0x%02h expected=0x%02h", it.tag, busRdData, it.exp);
        end
      end
    end
  end

  task automatic expectRd(input logic [1:0] a, input logic [7:0] e, input string tag);
    item_t it;
    busAddr = a;
    it.tag = tag;
    it.exp = e;
    sbq.push_back(it);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic runWindow(input int n);
    wr(2'd3, 8'hFF);
    repeat (n - 1) @(negedge clk);
    wr(2'd3, 8'hF7);
  endtask

  task automatic pulse(input int h);
    evtPin = 1'b1;
    repeat (h) @(negedge clk);
    evtPin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic directChk(input int act, input int e, input string tag);
    total++;
    if (act != e) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectRd(2'd0, 8'h00, "R1 low reset");
    expectRd(2'd1, 8'h00, "R1 high reset");
    expectRd(2'd2, 8'h00, "R1 ctl reset");
    expectRd(2'd3, 8'hFF, "R1 stby reset");

    wr(2'd3, 8'hF7);
    expectRd(2'd3, 8'hF7, "R2 stby readback");
    wr(2'd2, 8'h07);
    expectRd(2'd2, 8'h07, "R2 ctl readback");
    wr(2'd2, 8'h32);
    expectRd(2'd2, 8'h02, "R2 R5 clear bits not stored");

    runWindow(20);
    expectRd(2'd0, 8'd10, "R4 div2 low");
    expectRd(2'd1, 8'd10, "R9 div2 high split");
    repeat (30) @(negedge clk);
    expectRd(2'd0, 8'd10, "R7 hold low");

    wr(2'd0, 8'h55);
    wr(2'd1, 8'hAA);
    expectRd(2'd0, 8'd10, "R3 low write ignored");
    expectRd(2'd1, 8'd10, "R3 high write ignored");

    wr(2'd2, 8'h34);
    expectRd(2'd0, 8'h00, "R5 clear low in standby");
    expectRd(2'd1, 8'h00, "R5 clear high in standby");
    runWindow(24);
    expectRd(2'd0, 8'd6, "R4 div4 low");
    expectRd(2'd1, 8'd6, "R9 div4 high");

    wr(2'd2, 8'h36);
    runWindow(40);
    expectRd(2'd0, 8'd5, "R4 div8 low");
    expectRd(2'd1, 8'd5, "R9 div8 high");
    wr(2'd2, 8'h16);
    expectRd(2'd0, 8'd0, "R5 clear low only");
    expectRd(2'd1, 8'd5, "R5 high untouched");

    // event pin source
    wr(2'd2, 8'h30);
    wr(2'd3, 8'hFF);
    repeat (4) @(negedge clk);
    evtPin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expectRd(2'd0, 8'd0, "R6 before third edge");
    expectRd(2'd0, 8'd1, "R6 at third edge");
    repeat (18) @(negedge clk);
    evtPin = 1'b0;
    repeat (4) @(negedge clk);
    expectRd(2'd0, 8'd1, "R6 held level counts once");
    pulse(2);
    pulse(2);
    expectRd(2'd0, 8'd3, "R6 pulse count low");
    expectRd(2'd1, 8'd3, "R9 pulse count high");

    // clear landing on the increment edge
    evtPin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr(2'd2, 8'h10);
    expectRd(2'd0, 8'd0, "R5 clear beats count");
    expectRd(2'd1, 8'd4, "R9 high counted same edge");
    evtPin = 1'b0;
    repeat (4) @(negedge clk);
    pulse(2);
    expectRd(2'd0, 8'd1, "R6 count after clear");

    wr(2'd3, 8'hF7);
    pulse(2);
    expectRd(2'd0, 8'd1, "R7 pin ignored low");
    expectRd(2'd1, 8'd5, "R7 pin ignored high");

    // cascade
    wr(2'd2, 8'h33);
    runWindow(600);
    expectRd(2'd0, 8'h2C, "R8 cascade low");
    expectRd(2'd1, 8'h01, "R8 cascade high");
    directChk(carryCnt, 0, "R10 no carry yet");

    wr(2'd2, 8'h33);
    runWindow(131082);
    expectRd(2'd0, 8'h05, "R8 wrap low");
    expectRd(2'd1, 8'h00, "R8 wrap high");
    directChk(carryCnt, 1, "R10 one carry pulse");

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule